// File: doc/BRIEF.md
# Oversampled I2C Slave Receive Front End with High-Speed Entry

This block is the receive side of an I2C slave running on a system clock much faster than SCL. Both bus lines pass through a synchroniser and a glitch filter. From the filtered lines it derives clock edges and the START and STOP conditions. A state machine then shifts in the address byte and decides whether to acknowledge it. It answers a device address made of a fixed five-bit prefix and two strap pins, and also a broadcast address that is valid for writes only. After an accepted address, every data byte is handed downstream and acknowledged by pulling SDA low.

The block notices the high-speed master code (`00001xxx`) and never acknowledges it. It raises `hs_mode`, which stays high across repeated STARTs and drops only on a STOP. Downstream logic receives one-cycle strobes:
- `rx_valid` carries a received data byte.
- `start_stb` and `stop_stb` mark bus conditions.
- `ack_fall` marks the SCL falling edge that ends an acknowledged ninth bit, which is the point where downstream logic can commit its data.

The controller has six states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the address acknowledge is driven.
- `ST_DATA`: a data byte is being shifted in.
- `ST_DATA_ACK`: the data acknowledge is driven.
- `ST_IGNORE`: the block waits for the next bus condition.

Its transitions are:
- From any state, a STOP goes to `ST_IDLE` and a START goes to `ST_ADDR`.
- In `ST_ADDR`, the SCL fall after the eighth bit goes to `ST_ADDR_ACK` on a match, otherwise to `ST_IGNORE`.
- `ST_ADDR_ACK` goes to `ST_DATA` on the next SCL fall.
- In `ST_DATA`, the SCL fall after the eighth bit goes to `ST_DATA_ACK`.
- `ST_DATA_ACK` goes back to `ST_DATA` on the next SCL fall.

Top module: `i2c_hs_slave_fe`

## Requirements
- R1: A falling SDA while filtered SCL is high gives one `start_stb` pulse. This holds for a first START and for a repeated START, and either one restarts address reception.
- R2: A rising SDA while filtered SCL is high gives one `stop_stb` pulse and returns the block to idle. No acknowledge is then driven until a new START and a matching address have been seen.
- R3: A pulse on either bus line that is shorter than `FILT_LEN` system clocks does not reach the detectors, so it produces no START or STOP strobe.
- R4: The address byte is received MSB first, and bit 0 is the read/write bit (0 means write). The block acknowledges the address `{5'b10011, strap[1:0], 1'b0}`. The same address with bit 0 set to 1 (a read) is not acknowledged.
- R5: The strap pins are sampled once, on the first clock after reset. Later changes on the pins do not change the address that is answered.
- R6: The broadcast byte `8'h90` is acknowledged whatever the straps are, and `bcast_sel` goes high for that transfer. The broadcast byte with the read bit set (`8'h91`) is not acknowledged.
- R7: The general call byte `8'h00`, ten-bit address headers (`11110xx_x`) and any other non-matching byte are not acknowledged. Data bytes that follow them are neither acknowledged nor delivered.
- R8: An address-phase byte of the form `00001xxx` is not acknowledged and sets `hs_mode`.
- R9: `hs_mode` stays set across repeated STARTs and is cleared only by a STOP.
- R10: After an accepted address, each data byte is presented MSB first on `rx_data`, with a one-cycle `rx_valid`, after its eighth SCL fall. SDA is then held low (`sda_oe` = 1) through the ninth SCL high period.
- R11: `ack_fall` pulses once for each acknowledged byte, address or data, on the SCL fall that ends the ninth bit. `sda_oe` is released at the same time.
- R12: After reset the block is idle, and `sda_oe`, `hs_mode`, `bcast_sel` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_a | input | 2 | Address strap pins, sampled once after reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new data byte |
| rx_data | output | 8 | Last received data byte |
| start_stb | output | 1 | One-cycle START / repeated START strobe |
| stop_stb | output | 1 | One-cycle STOP strobe |
| ack_fall | output | 1 | One-cycle strobe at the SCL fall ending an acknowledged ninth bit |
| hs_mode | output | 1 | High-speed mode flag |
| bcast_sel | output | 1 | Current transfer was addressed by the broadcast byte |

## Verification
The hardest situation to reach is the high-speed sequence: an unacknowledged master code, a repeated START with no STOP, a matching address, and data while `hs_mode` stays high. This must be followed by a check that only the STOP clears the flag. The bench drives this as a directed sequence with two repeated STARTs. It also mixes random address bytes into the random loop, so that master codes and non-matching bytes also occur between normal transfers. Sub-filter glitches on an idle bus and strap changes after reset are also directed, because random bus traffic never produces them.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } fe_state_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2cfe_line_filter.sv
module i2cfe_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_s;
    logic [CW-1:0]          cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign sync_s = sync_q[SYNC_STAGES-1];

    // output follows the synchronised line only after it has differed
    // for FILT_LEN consecutive clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_o <= 1'b1;
            cnt    <= '0;
        end else if (sync_s == line_o) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
            line_o <= sync_s;
            cnt    <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/i2cfe_cond_detect.sv
module i2cfe_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_d;
        scl_fall  = ~scl_f & scl_d;
        start_det = scl_f & scl_d & sda_d & ~sda_f;
        stop_det  = scl_f & scl_d & ~sda_d & sda_f;
    end

endmodule

// File: rtl/i2cfe_fsm.sv
module i2cfe_fsm
    import i2cfe_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b10011,
    parameter logic [7:0] BCAST_ADDR  = 8'h90,
    parameter logic [4:0] HS_PREFIX   = 5'b00001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_q,
    input  logic       sda_f,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       sda_oe,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       ack_fall,
    output logic       hs_mode,
    output logic       bcast_sel
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    fe_state_t        state, next_state;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] bitcnt;
    logic             byte_full;
    logic             own_hit;
    logic             bc_hit;
    logic             hs_hit;
    logic             addr_ok;

    assign byte_full = (bitcnt == CNT_W'(BYTE_BITS));
    assign own_hit   = (shreg == {ADDR_PREFIX, strap_q, 1'b0});
    assign bc_hit    = (shreg == BCAST_ADDR);
    assign hs_hit    = (shreg[7:3] == HS_PREFIX);
    assign addr_ok   = own_hit | bc_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // next-state decision
    always_comb begin
        next_state = state;
        if (stop_det) begin
            next_state = ST_IDLE;
        end else if (start_det) begin
            next_state = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     next_state = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_full)
                                 next_state = addr_ok ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) next_state = ST_DATA;
                ST_DATA:     if (scl_fall && byte_full) next_state = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) next_state = ST_DATA;
                ST_IGNORE:   next_state = ST_IGNORE;
                default:     next_state = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            default:                  sda_oe = 1'b0;
        endcase
    end

    // shifter, counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            hs_mode   <= 1'b0;
            bcast_sel <= 1'b0;
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            ack_fall  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            ack_fall <= 1'b0;
            if (stop_det) begin
                bitcnt    <= '0;
                hs_mode   <= 1'b0;
                bcast_sel <= 1'b0;
            end else if (start_det) begin
                bitcnt    <= '0;
                bcast_sel <= 1'b0;
            end else begin
                if ((state == ST_ADDR || state == ST_DATA) && scl_rise && !byte_full) begin
                    shreg  <= {shreg[6:0], sda_f};
                    bitcnt <= bitcnt + CNT_W'(1);
                end
                if (state == ST_ADDR && scl_fall && byte_full) begin
                    bitcnt <= '0;
                    if (hs_hit) hs_mode <= 1'b1;
                    bcast_sel <= bc_hit;
                end
                if (state == ST_DATA && scl_fall && byte_full) begin
                    bitcnt   <= '0;
                    rx_valid <= 1'b1;
                    rx_data  <= shreg;
                end
                if ((state == ST_ADDR_ACK || state == ST_DATA_ACK) && scl_fall)
                    ack_fall <= 1'b1;
            end
        end
    end

    // R9
    stop_clears_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    // R8
    hs_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> !sda_oe);

    // R10
    data_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> sda_oe);

    // R11
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fall |-> !sda_oe);

    // R4
    ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

endmodule

// File: rtl/i2c_hs_slave_fe.sv
module i2c_hs_slave_fe #(
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4,
    parameter logic [4:0] ADDR_PREFIX = 5'b10011,
    parameter logic [7:0] BCAST_ADDR  = 8'h90
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_a,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       start_stb,
    output logic       stop_stb,
    output logic       ack_fall,
    output logic       hs_mode,
    output logic       bcast_sel
);
    logic [1:0] strap_q;
    logic       strap_done;
    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall;

    // straps captured once, on the first clock after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q    <= '0;
            strap_done <= 1'b0;
        end else if (!strap_done) begin
            strap_q    <= strap_a;
            strap_done <= 1'b1;
        end
    end

    // R5
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && $past(strap_done)) |-> $stable(strap_q));

    i2cfe_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );

    i2cfe_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    i2cfe_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_stb),
        .stop_det  (stop_stb)
    );

    i2cfe_fsm #(.ADDR_PREFIX(ADDR_PREFIX), .BCAST_ADDR(BCAST_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_q   (strap_q),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_stb),
        .stop_det  (stop_stb),
        .sda_oe    (sda_oe),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .ack_fall  (ack_fall),
        .hs_mode   (hs_mode),
        .bcast_sel (bcast_sel)
    );

endmodule

// File: tb/tb_i2c_hs_slave_fe.sv
module tb_i2c_hs_slave_fe;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe, rx_valid, start_stb, stop_stb, ack_fall, hs_mode, bcast_sel;
    logic [7:0] rx_data;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_oe;

    i2c_hs_slave_fe dut (
        .clk(clk), .rst_n(rst_n), .strap_a(strap), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
        .start_stb(start_stb), .stop_stb(stop_stb), .ack_fall(ack_fall),
        .hs_mode(hs_mode), .bcast_sel(bcast_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_err = 0;
    int n_start = 0, n_stop = 0, n_ackf = 0, rx_n = 0;
    logic [7:0] rx_buf [0:255];
    bit done = 1'b0;
    logic [1:0] strap_eff = 2'b10;

    always @(posedge clk) begin
        if (rst_n) begin
            if (start_stb) n_start++;
            if (stop_stb)  n_stop++;
            if (ack_fall)  n_ackf++;
            if (rx_valid) begin
                rx_buf[rx_n % 256] = rx_data;
                rx_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_sda = 1'b0; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input bit b, output bit seen);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(Q);
        seen = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        acked = ~s;
    endtask

    function automatic bit exp_addr_ack(input logic [7:0] b);
        return (b == {5'b10011, strap_eff, 1'b0}) || (b == 8'h90);
    endfunction

    function automatic bit is_hs(input logic [7:0] b);
        return b[7:3] == 5'b00001;
    endfunction

    // full write transfer with per-byte and delivery checks
    task automatic xfer(input logic [7:0] addr, input int nd, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input string tag);
        bit a;
        bit ea;
        int rx0, af0;
        logic [7:0] dv;
        rx0 = rx_n; af0 = n_ackf;
        ea = exp_addr_ack(addr);
        bus_start();
        send_byte(addr, a);
        check(a == ea, tag, int'(a), int'(ea));
        for (int k = 0; k < nd; k++) begin
            dv = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
            send_byte(dv, a);
            check(a == ea, {tag, " R10 data ack"}, int'(a), int'(ea));
        end
        bus_stop();
        check((rx_n - rx0) == (ea ? nd : 0), {tag, " R10/R7 delivered count"}, rx_n - rx0, ea ? nd : 0);
        if (ea) begin
            for (int k = 0; k < nd; k++) begin
                dv = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
                check(rx_buf[(rx0 + k) % 256] == dv, {tag, " R10 data value"},
                      int'(rx_buf[(rx0 + k) % 256]), int'(dv));
            end
        end
        check((n_ackf - af0) == (ea ? nd + 1 : 0), {tag, " R11 ack_fall count"},
              n_ackf - af0, ea ? nd + 1 : 0);
        check(hs_mode == 1'b0, {tag, " R9 hs cleared by stop"}, int'(hs_mode), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        bit a;
        int s0, p0, rx0, af0;
        logic [7:0] rb;
        int nd;
        void'($urandom(32'd4242));
        tick(5);
        rst_n = 1'b1;
        tick(3);
        strap = 2'b01;  // later pin changes must be ignored
        // R12 reset state
        check({sda_oe, hs_mode, bcast_sel, rx_valid, ack_fall} == 5'b0, "R12 reset outputs",
              int'({sda_oe, hs_mode, bcast_sel, rx_valid, ack_fall}), 0);
        tick(10);

        // R3 short glitches on an idle bus
        s0 = n_start; p0 = n_stop;
        m_sda = 1'b0; tick(2); m_sda = 1'b1; tick(20);
        m_scl = 1'b0; tick(2); m_scl = 1'b1; tick(20);
        check(n_start == s0, "R3 glitch no start", n_start - s0, 0);
        check(n_stop == p0, "R3 glitch no stop", n_stop - p0, 0);

        // R1 R2 R4 R5 R10 R11 own address with two data bytes
        s0 = n_start; p0 = n_stop;
        xfer(8'h9C, 2, 8'hA5, 8'h3C, 8'h00, "R4 own write");
        check(n_start - s0 == 1, "R1 start count", n_start - s0, 1);
        check(n_stop - p0 == 1, "R2 stop count", n_stop - p0, 1);
        check(sda_oe == 1'b0, "R2 idle after stop", int'(sda_oe), 0);

        // R5 new strap value not answered
        xfer(8'h9A, 1, 8'h11, 8'h00, 8'h00, "R5 late strap");
        // R4 read not acked
        xfer(8'h9D, 1, 8'h22, 8'h00, 8'h00, "R4 read");

        // R6 broadcast
        bus_start();
        send_byte(8'h90, a);
        check(a, "R6 broadcast ack", int'(a), 1);
        check(bcast_sel == 1'b1, "R6 bcast_sel", int'(bcast_sel), 1);
        send_byte(8'h77, a);
        check(a, "R6 broadcast data ack", int'(a), 1);
        bus_stop();
        check(rx_buf[(rx_n - 1) % 256] == 8'h77, "R6 broadcast data", int'(rx_buf[(rx_n - 1) % 256]), 8'h77);
        xfer(8'h91, 1, 8'h33, 8'h00, 8'h00, "R6 broadcast read");

        // R7 general call and ten-bit header
        xfer(8'h00, 2, 8'h44, 8'h55, 8'h00, "R7 general call");
        xfer(8'hF0, 1, 8'h66, 8'h00, 8'h00, "R7 ten-bit");

        // R8 R9 high-speed entry, repeated starts, then stop
        s0 = n_start; rx0 = rx_n; af0 = n_ackf;
        bus_start();
        send_byte(8'h0B, a);
        check(!a, "R8 master code not acked", int'(a), 0);
        check(hs_mode == 1'b1, "R8 hs set", int'(hs_mode), 1);
        bus_start();
        check(hs_mode == 1'b1, "R9 hs kept over repeated start", int'(hs_mode), 1);
        send_byte(8'h9C, a);
        check(a, "R9 address in hs mode", int'(a), 1);
        send_byte(8'h12, a);
        check(a, "R10 data in hs mode", int'(a), 1);
        bus_start();
        check(hs_mode == 1'b1, "R9 hs kept second repeated start", int'(hs_mode), 1);
        check(n_start - s0 == 3, "R1 repeated start count", n_start - s0, 3);
        bus_stop();
        check(hs_mode == 1'b0, "R9 hs cleared", int'(hs_mode), 0);
        check(rx_n - rx0 == 1 && rx_buf[rx0 % 256] == 8'h12, "R10 hs data value",
              int'(rx_buf[rx0 % 256]), 8'h12);
        check(n_ackf - af0 == 2, "R11 hs ack_fall count", n_ackf - af0, 2);

        // random mix
        for (int t = 0; t < 20; t++) begin
            case ($urandom % 4)
                0: rb = 8'h9C;
                1: rb = 8'h90;
                2: rb = 8'($urandom);
                default: rb = 8'h9D;
            endcase
            nd = 1 + int'($urandom % 3);
            rx0 = rx_n;
            if (is_hs(rb)) begin
                bus_start();
                send_byte(rb, a);
                check(!a && hs_mode, "R8 random master code", int'(hs_mode), 1);
                bus_stop();
                check(!hs_mode, "R9 random hs stop", int'(hs_mode), 0);
            end else begin
                xfer(rb, nd, 8'($urandom), 8'($urandom), 8'($urandom), "R4/R6/R7 random");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule